// File: doc/BRIEF.md
# Glitch-free power-of-two clock divider

This block sits behind a clock source and produces a slower clock from it. A 3-bit code selects a ratio of 1, 2, 4 and so on up to 128. Ratios of 2 and above come from a half-period counter that toggles a registered output. Ratio 1 passes the source clock through, and so does bypass mode. A ratio update is taken only while the lock input reports a stable source. The update waits in a pending register until a safe point of the output clock, so every pulse the output produces has full width.

The safe point is the first source falling edge that follows a falling edge of the output. While the output is the source clock itself, every source falling edge is a safe point. At that moment the output is low whichever path drives it. The pending code and the bypass request are copied into the active selection there, and the output mux switches only then. The source is never told about a ratio change, so no lock wait is inserted.

Top module: `pow2_clk_div`

## Requirements
- R1: Code k (0 to 7) gives an output period of 2^k source cycles: 000 gives 1, 001 gives 2, 010 gives 4, 011 gives 8, 100 gives 16, 101 gives 32, 110 gives 64 and 111 gives 128.
- R2: A new code takes effect only at the first source falling edge after the output's next falling edge. The output's current high phase ends at its old length.
- R3: A write (`ratio_wr` high at a source rising edge) is recorded only if `lock_ok` is high in the same cycle. Otherwise it is discarded and neither the output nor `ratio_now` changes.
- R4: While bypass is in effect the output equals the source clock whatever the code. A code written during bypass is kept, and it takes effect once bypass is released.
- R5: With code 000 the output is the source clock: high for one source half-cycle, then low for one.
- R6: Every ratio of 2 or more gives a 50 percent duty cycle, high for 2^(k-1) source cycles and then low for the same time.
- R7: Synchronous reset clears the pending and active codes to 000 and the counter to zero. Afterwards the output follows the source clock.
- R8: `ratio_now` reports the active code, meaning the last one committed at a safe point. It does so even while bypass hides that code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_src | input | 1 | Source clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| ratio_code | input | 3 | Requested ratio code |
| ratio_wr | input | 1 | Write strobe for `ratio_code` |
| lock_ok | input | 1 | Source-stable status; gates writes |
| bypass | input | 1 | Forces the output to the source clock |
| clk_div | output | 1 | Divided output clock |
| ratio_now | output | 3 | Code currently in effect |

## Verification
A counter that runs one step too far or wraps early shows as a wrong high or low length. It appears within the first output period measured after the code settles, because the bench counts both phases in source half-cycles. A shadow register that commits at the wrong moment changes `ratio_now` within half a source cycle of the wrong edge. It also shortens the high phase during which the write arrived, and the deferral scenario counts that phase exactly. A lock gate or bypass path that leaks shows up as a changed period or a changed `ratio_now` within one old output period after the discarded or hidden write.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;

    parameter int unsigned RATIO_W = 3;
    // Largest exponent, and width of a half-period counter for it
    localparam int unsigned MAX_SHIFT = (1 << RATIO_W) - 1;
    localparam int unsigned HALF_W    = (MAX_SHIFT > 1) ? MAX_SHIFT - 1 : 1;

    typedef logic [RATIO_W-1:0] ratio_t;
    typedef logic [HALF_W-1:0]  half_t;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } phase_e;

    // Active selection, changed only at a safe point
    typedef struct packed {
        ratio_t code;
        logic   bypass;
    } sel_t;

    // Terminal count of one half period for code c (c >= 1)
    function automatic half_t half_limit(ratio_t c);
        logic [HALF_W:0] span;
        if (c == '0) begin
            return '0;
        end
        span = (HALF_W+1)'(1) << (c - ratio_t'(1));
        span = span - (HALF_W+1)'(1);
        return span[HALF_W-1:0];
    endfunction

    // True when the output is the source clock itself
    function automatic logic is_pass(sel_t s);
        return s.bypass || (s.code == '0);
    endfunction

endpackage

// File: rtl/ratio_shadow.sv
`timescale 1ns/1ps
module ratio_shadow
    import clkdiv_pkg::*;
(
    input  logic   clk_src,
    input  logic   rst,
    input  ratio_t ratio_code,
    input  logic   ratio_wr,
    input  logic   lock_ok,
    input  logic   bypass,
    input  logic   fell_q,
    output sel_t   sel_q
);

    ratio_t pend_q;
    logic   commit;

    // Pending code: written only while the source reports lock
    always_ff @(posedge clk_src) begin
        if (rst) begin
            pend_q <= '0;
        end else if (ratio_wr && lock_ok) begin
            pend_q <= ratio_code;
        end
    end

    // Safe point: output is low and will not rise before the next source edge
    assign commit = is_pass(sel_q) || fell_q;

    always_ff @(negedge clk_src) begin
        if (rst) begin
            sel_q <= '0;
        end else if (commit) begin
            sel_q <= '{code: pend_q, bypass: bypass};
        end
    end

    // R3: pending code moves only after an accepted write
    a_r3_lock_gate : assert property (@(posedge clk_src) disable iff (rst)
        (pend_q != $past(pend_q)) |-> $past(ratio_wr && lock_ok));

    // R2: active selection moves only at a safe point
    a_r2_safe_commit : assert property (@(negedge clk_src) disable iff (rst)
        (sel_q != $past(sel_q)) |-> $past(commit));

endmodule

// File: rtl/half_counter.sv
`timescale 1ns/1ps
module half_counter
    import clkdiv_pkg::*;
(
    input  logic   clk_src,
    input  logic   rst,
    input  sel_t   sel,
    output phase_e phase_q,
    output logic   fell_q
);

    half_t cnt_q;
    half_t lim;
    logic  pass;

    assign pass = is_pass(sel);
    assign lim  = half_limit(sel.code);

    always_ff @(posedge clk_src) begin
        if (rst || pass) begin
            cnt_q   <= '0;
            phase_q <= PH_LOW;
            fell_q  <= 1'b0;
        end else if (cnt_q == lim) begin
            cnt_q   <= '0;
            phase_q <= (phase_q == PH_HIGH) ? PH_LOW : PH_HIGH;
            fell_q  <= (phase_q == PH_HIGH);
        end else begin
            cnt_q   <= cnt_q + half_t'(1);
            fell_q  <= 1'b0;
        end
    end

    // R4: the divider path is parked low while passing the source through
    a_r4_parked_low : assert property (@(posedge clk_src) disable iff (rst)
        pass |=> (phase_q == PH_LOW));

    // R6: a commit never leaves the counter beyond the new half period
    a_r6_count_bound : assert property (@(posedge clk_src) disable iff (rst)
        !pass |-> (cnt_q <= lim));

endmodule

// File: rtl/clk_out_mux.sv
`timescale 1ns/1ps
module clk_out_mux
    import clkdiv_pkg::*;
(
    input  logic   clk_src,
    input  phase_e phase,
    input  logic   pass,
    output logic   clk_out
);

    always_comb begin
        clk_out = pass ? clk_src : (phase == PH_HIGH);
    end

endmodule

// File: rtl/pow2_clk_div.sv
`timescale 1ns/1ps
module pow2_clk_div
    import clkdiv_pkg::*;
(
    input  logic               clk_src,
    input  logic               rst,
    input  logic [RATIO_W-1:0] ratio_code,
    input  logic               ratio_wr,
    input  logic               lock_ok,
    input  logic               bypass,
    output logic               clk_div,
    output logic [RATIO_W-1:0] ratio_now
);

    sel_t   sel_q;
    phase_e phase_q;
    logic   fell_q;
    logic   pass;

    ratio_shadow u_shadow (
        .clk_src    (clk_src),
        .rst        (rst),
        .ratio_code (ratio_code),
        .ratio_wr   (ratio_wr),
        .lock_ok    (lock_ok),
        .bypass     (bypass),
        .fell_q     (fell_q),
        .sel_q      (sel_q)
    );

    half_counter u_count (
        .clk_src (clk_src),
        .rst     (rst),
        .sel     (sel_q),
        .phase_q (phase_q),
        .fell_q  (fell_q)
    );

    assign pass      = is_pass(sel_q);
    assign ratio_now = sel_q.code;

    clk_out_mux u_mux (
        .clk_src (clk_src),
        .phase   (phase_q),
        .pass    (pass),
        .clk_out (clk_div)
    );

    // R7: reset leaves code 000 active at the next source falling edge
    a_r7_reset_code : assert property (@(negedge clk_src)
        $past(rst) |-> (ratio_now == '0));

endmodule

// File: tb/pow2_clk_div_bench.sv
`timescale 1ns/1ps
module pow2_clk_div_bench;

    logic       clk_src = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] ratio_code = '0;
    logic       ratio_wr = 1'b0;
    logic       lock_ok = 1'b1;
    logic       bypass = 1'b0;
    logic       clk_div;
    logic [2:0] ratio_now;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk_src = ~clk_src;

    pow2_clk_div u_pow2_clk_div (
        .clk_src    (clk_src),
        .rst        (rst),
        .ratio_code (ratio_code),
        .ratio_wr   (ratio_wr),
        .lock_ok    (lock_ok),
        .bypass     (bypass),
        .clk_div    (clk_div),
        .ratio_now  (ratio_now)
    );

    task automatic check(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // One sample 1 ns after every source edge
    task automatic sample(output logic b);
        @(posedge clk_src or negedge clk_src);
        #1;
        b = clk_div;
    endtask

    // Lengths in source half-cycles of one full output period
    task automatic measure(output int hi, output int per);
        logic b;
        do sample(b); while (b);
        do sample(b); while (!b);
        hi = 1;
        per = 1;
        sample(b);
        while (b) begin hi++; per++; sample(b); end
        per++;
        sample(b);
        while (!b) begin per++; sample(b); end
    endtask

    task automatic write_code(logic [2:0] k, logic lk);
        @(posedge clk_src);
        #1;
        ratio_code = k;
        ratio_wr = 1'b1;
        lock_ok = lk;
        @(posedge clk_src);
        #1;
        ratio_wr = 1'b0;
        lock_ok = 1'b1;
    endtask

    task automatic wait_code(logic [2:0] k);
        logic b;
        while (ratio_now != k) sample(b);
    endtask

    task automatic t_reset();
        int hi, per;
        repeat (4) @(posedge clk_src);
        #1 rst = 1'b0;
        check("R7", "ratio_now after reset", ratio_now, 0);
        measure(hi, per);
        check("R7", "period after reset", per, 2);
        check("R5", "high after reset", hi, 1);
    endtask

    task automatic t_all_codes();
        int hi, per;
        for (int k = 1; k < 8; k++) begin
            write_code(3'(k), 1'b1);
            wait_code(3'(k));
            check("R8", "ratio_now", ratio_now, k);
            measure(hi, per);
            check("R1", "period", per, 2 * (1 << k));
            check("R6", "high phase", hi, 1 << k);
        end
        write_code(3'd0, 1'b1);
        wait_code(3'd0);
        measure(hi, per);
        check("R5", "period code 000", per, 2);
        check("R5", "high code 000", hi, 1);
    endtask

    task automatic t_deferral();
        int hi, per;
        logic b;
        write_code(3'd7, 1'b1);
        wait_code(3'd7);
        do sample(b); while (b);
        do sample(b); while (!b);
        hi = 1;
        ratio_code = 3'd1;
        ratio_wr = 1'b1;
        sample(b);
        if (b) hi++;
        sample(b);
        if (b) hi++;
        ratio_wr = 1'b0;
        check("R2", "code held mid-phase", ratio_now, 7);
        sample(b);
        while (b) begin hi++; sample(b); end
        check("R2", "old high phase length", hi, 128);
        check("R2", "code held at fall", ratio_now, 7);
        sample(b);
        check("R2", "code after safe point", ratio_now, 1);
        measure(hi, per);
        check("R2", "new period", per, 4);
    endtask

    task automatic t_lock_gate();
        int hi, per;
        logic b;
        write_code(3'd5, 1'b0);
        repeat (200) sample(b);
        check("R3", "code after unlocked write", ratio_now, 1);
        measure(hi, per);
        check("R3", "period after unlocked write", per, 4);
    endtask

    task automatic t_bypass();
        int hi, per;
        logic b;
        bypass = 1'b1;
        repeat (8) sample(b);
        measure(hi, per);
        check("R4", "period in bypass", per, 2);
        write_code(3'd3, 1'b1);
        repeat (4) sample(b);
        check("R8", "code stored in bypass", ratio_now, 3);
        measure(hi, per);
        check("R4", "period bypass after write", per, 2);
        check("R4", "high bypass after write", hi, 1);
        bypass = 1'b0;
        repeat (4) sample(b);
        measure(hi, per);
        check("R4", "period after release", per, 16);
        check("R6", "high after release", hi, 8);
    endtask

    task automatic t_mid_reset();
        int hi, per;
        write_code(3'd5, 1'b1);
        wait_code(3'd5);
        @(posedge clk_src);
        #1 rst = 1'b1;
        repeat (4) @(posedge clk_src);
        #1 rst = 1'b0;
        check("R7", "code after mid-run reset", ratio_now, 0);
        measure(hi, per);
        check("R7", "period after mid-run reset", per, 2);
    endtask

    initial begin
        t_reset();
        t_all_codes();
        t_deferral();
        t_lock_gate();
        t_bypass();
        t_mid_reset();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #750000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule